// File: doc/BRIEF.md
# Interrupt Controller Setup-Word Sequencer

This block sits on the host side of a programmable interrupt controller. It accepts byte writes from a bus with a single address line, recognises the word that opens a setup sequence, and steps through the setup words that follow. Each word it accepts is stored in the controller's configuration registers. Flags in the opening word decide whether the cascade-map word and the mode word are expected. A word that is skipped leaves its fields at zero.

Once the last expected word has been taken, the block raises a ready flag and treats further writes as run-time commands. Writes on address 1 load the per-line mask register. Writes on address 0 whose bit 4 is clear are passed on, one cycle later, as a command byte with a strobe. The priority and end-of-service logic that consumes this byte is outside this block.

All configuration fields are exported as flat outputs for the controller core. Every output is a register, so a write is visible on the cycle after the clock edge that takes it.

Top module: `pic_init_seq`

## Requirements
- R1: After reset, `ready_o`, `cmd_valid_o`, `mask_o` and every configuration output are zero.
- R2: A write at address 0 with data bit 4 set restarts the sequence from any state. It takes effect on the next cycle. From that write, `word4_req_o` takes bit 0, `single_o` takes bit 1, `interval4_o` takes bit 2, `level_trig_o` takes bit 3 and `addr_hi_o` takes bits 7:5. The same write clears `ready_o`, `mask_o`, `vec_base_o`, `cascade_o` and all mode-word fields.
- R3: The first write at address 1 after the opening word is always taken as the second word and loads `vec_base_o`.
- R4: The cascade-map word is expected only when `single_o` is 0. The next address-1 write then loads `cascade_o`, which is a slave-presence map for a master or holds the slave ID in bits 2:0 for a slave.
- R5: The mode word is expected only when `word4_req_o` is 1. Its bit 4 loads `special_nest_o`, bit 2 loads `is_master_o`, bit 1 loads `auto_eoi_o` and bit 0 loads `proc_mode_o`. Other bits are dropped.
- R6: A skipped cascade-map word or mode word leaves its outputs at zero.
- R7: `ready_o` rises on the cycle after the last expected word is accepted and not before.
- R8: While `ready_o` is 1, an address-1 write loads `mask_o` on the next cycle. Bit n masks line n.
- R9: While `ready_o` is 1, an address-0 write with bit 4 clear gives `cmd_valid_o` high for exactly one cycle on the next cycle, with `cmd_data_o` equal to the written byte.
- R10: While `ready_o` is 0, an address-0 write with bit 4 clear is ignored. It produces no command strobe and changes no output.
- R11: A cycle without a write changes no output, and `cmd_valid_o` is 0 on the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 1 | Register address line |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Setup complete, run-time commands accepted |
| word4_req_o | output | 1 | Mode word requested by the opening word |
| single_o | output | 1 | 1 = single controller, 0 = cascaded |
| interval4_o | output | 1 | Address interval select |
| level_trig_o | output | 1 | 1 = level trigger, 0 = edge trigger |
| addr_hi_o | output | 3 | Service address bits from the opening word |
| vec_base_o | output | 8 | Vector number or high address byte |
| cascade_o | output | 8 | Slave-presence map or slave ID |
| special_nest_o | output | 1 | Special fully nested mode |
| is_master_o | output | 1 | Master/slave flag |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt |
| proc_mode_o | output | 1 | Processor-mode select |
| mask_o | output | 8 | Per-line interrupt mask |
| cmd_valid_o | output | 1 | One-cycle run-time command strobe |
| cmd_data_o | output | 8 | Run-time command byte |

## Verification
The bound checker enforces, on every cycle, the local laws of the write protocol. An opening word clears the ready flag and the mask. A mask write or command write in the ready state lands one cycle later with the written byte. Writes with bit 4 clear before ready, and idle cycles, leave the outputs alone. In the ready state, skipped words read as zero. Whether the sequencer expects the right number of words for each combination of the single and mode-word flags can only be shown by the bench's scenarios. The same holds for whether ready rises after exactly the last expected word, and for whether a restart in the middle of a sequence discards the partial state. The bench tracks all of these against a behavioural model on every clock.

// File: rtl/pic_cfg_pkg.sv
package pic_cfg_pkg;
  localparam int DW     = 8;
  localparam int AHI_W  = 3;
  // opening-word bit positions
  localparam int B_W4   = 0;
  localparam int B_SNG  = 1;
  localparam int B_INTV = 2;
  localparam int B_LVL  = 3;
  localparam int B_INIT = 4;
  localparam int B_AHI  = 5;
  // mode-word bit positions
  localparam int B_PM   = 0;
  localparam int B_AEOI = 1;
  localparam int B_MS   = 2;
  localparam int B_SFN  = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic             need4;
    logic             single;
    logic             intv;
    logic             level;
    logic [AHI_W-1:0] ahi;
  } word1_t;

  typedef struct packed {
    logic sfn;
    logic ms;
    logic aeoi;
    logic pm;
  } word4_t;
endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          single_i,
  input  logic          need4_i,
  output logic          ld1_o,
  output logic          ld2_o,
  output logic          ld3_o,
  output logic          ld4_o,
  output logic          mask_we_o,
  output logic          cmd_we_o,
  output logic          run_o
);
  seq_state_e state_q, state_d;
  logic hi_wr, lo_wr, start;

  assign hi_wr = wr_en_i & addr_i;
  assign lo_wr = wr_en_i & ~addr_i;
  assign start = lo_wr & wdata_i[B_INIT];

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_W2;
    end else if (hi_wr) begin
      unique case (state_q)
        ST_W2:   state_d = !single_i ? ST_W3 : (need4_i ? ST_W4 : ST_RUN);
        ST_W3:   state_d = need4_i ? ST_W4 : ST_RUN;
        ST_W4:   state_d = ST_RUN;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ld1_o     = start;
  assign ld2_o     = hi_wr & (state_q == ST_W2);
  assign ld3_o     = hi_wr & (state_q == ST_W3);
  assign ld4_o     = hi_wr & (state_q == ST_W4);
  assign mask_we_o = hi_wr & (state_q == ST_RUN);
  assign cmd_we_o  = lo_wr & ~wdata_i[B_INIT] & (state_q == ST_RUN);
  assign run_o     = (state_q == ST_RUN);
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          ld1_i,
  input  logic          ld2_i,
  input  logic          ld3_i,
  input  logic          ld4_i,
  output word1_t        w1_o,
  output logic [DW-1:0] vec_o,
  output logic [DW-1:0] casc_o,
  output word4_t        w4_o
);
  word1_t        w1_q;
  word4_t        w4_q;
  logic [DW-1:0] vec_q, casc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q   <= '0;
      w4_q   <= '0;
      vec_q  <= '0;
      casc_q <= '0;
    end else if (ld1_i) begin
      w1_q.need4  <= wdata_i[B_W4];
      w1_q.single <= wdata_i[B_SNG];
      w1_q.intv   <= wdata_i[B_INTV];
      w1_q.level  <= wdata_i[B_LVL];
      w1_q.ahi    <= wdata_i[B_AHI +: AHI_W];
      // later words default to zero until loaded
      w4_q   <= '0;
      vec_q  <= '0;
      casc_q <= '0;
    end else begin
      if (ld2_i) vec_q  <= wdata_i;
      if (ld3_i) casc_q <= wdata_i;
      if (ld4_i) begin
        w4_q.sfn  <= wdata_i[B_SFN];
        w4_q.ms   <= wdata_i[B_MS];
        w4_q.aeoi <= wdata_i[B_AEOI];
        w4_q.pm   <= wdata_i[B_PM];
      end
    end
  end

  assign w1_o   = w1_q;
  assign w4_o   = w4_q;
  assign vec_o  = vec_q;
  assign casc_o = casc_q;
endmodule

// File: rtl/pic_op_port.sv
module pic_op_port
  import pic_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  input  logic          mask_we_i,
  input  logic          cmd_we_i,
  output logic [DW-1:0] mask_o,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_data_o
);
  logic [DW-1:0] mask_q, cmd_q;
  logic          cv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      cmd_q  <= '0;
      cv_q   <= 1'b0;
    end else begin
      cv_q <= cmd_we_i;
      if (clr_i)          mask_q <= '0;
      else if (mask_we_i) mask_q <= wdata_i;
      if (cmd_we_i)       cmd_q  <= wdata_i;
    end
  end

  assign mask_o      = mask_q;
  assign cmd_valid_o = cv_q;
  assign cmd_data_o  = cmd_q;
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             ready_o,
  output logic             word4_req_o,
  output logic             single_o,
  output logic             interval4_o,
  output logic             level_trig_o,
  output logic [AHI_W-1:0] addr_hi_o,
  output logic [DW-1:0]    vec_base_o,
  output logic [DW-1:0]    cascade_o,
  output logic             special_nest_o,
  output logic             is_master_o,
  output logic             auto_eoi_o,
  output logic             proc_mode_o,
  output logic [DW-1:0]    mask_o,
  output logic             cmd_valid_o,
  output logic [DW-1:0]    cmd_data_o
);
  logic   ld1, ld2, ld3, ld4, mask_we, cmd_we;
  word1_t w1;
  word4_t w4;

  pic_init_fsm u_fsm (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .single_i  (w1.single),
    .need4_i   (w1.need4),
    .ld1_o     (ld1),
    .ld2_o     (ld2),
    .ld3_o     (ld3),
    .ld4_o     (ld4),
    .mask_we_o (mask_we),
    .cmd_we_o  (cmd_we),
    .run_o     (ready_o)
  );

  pic_cfg_regs u_regs (
    .clk_i, .rst_ni, .wdata_i,
    .ld1_i  (ld1),
    .ld2_i  (ld2),
    .ld3_i  (ld3),
    .ld4_i  (ld4),
    .w1_o   (w1),
    .vec_o  (vec_base_o),
    .casc_o (cascade_o),
    .w4_o   (w4)
  );

  pic_op_port u_op (
    .clk_i, .rst_ni, .wdata_i,
    .clr_i       (ld1),
    .mask_we_i   (mask_we),
    .cmd_we_i    (cmd_we),
    .mask_o      (mask_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_data_o  (cmd_data_o)
  );

  assign word4_req_o    = w1.need4;
  assign single_o       = w1.single;
  assign interval4_o    = w1.intv;
  assign level_trig_o   = w1.level;
  assign addr_hi_o      = w1.ahi;
  assign special_nest_o = w4.sfn;
  assign is_master_o    = w4.ms;
  assign auto_eoi_o     = w4.aeoi;
  assign proc_mode_o    = w4.pm;
endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk
  import pic_cfg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             ready_o,
  input logic             word4_req_o,
  input logic             single_o,
  input logic [DW-1:0]    vec_base_o,
  input logic [DW-1:0]    cascade_o,
  input logic             special_nest_o,
  input logic             is_master_o,
  input logic             auto_eoi_o,
  input logic             proc_mode_o,
  input logic [DW-1:0]    mask_o,
  input logic             cmd_valid_o,
  input logic [DW-1:0]    cmd_data_o
);
  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[B_INIT]) |=> (!ready_o && mask_o == '0 && vec_base_o == '0));

  p_single_no_map_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && single_o) |-> (cascade_o == '0));

  p_no_mode_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !word4_req_o) |-> !(special_nest_o || is_master_o || auto_eoi_o || proc_mode_o));

  p_mask_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_en_i && addr_i) |=> (mask_o == $past(wdata_i) && ready_o));

  p_cmd_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_en_i && !addr_i && !wdata_i[B_INIT]) |=> (cmd_valid_o && cmd_data_o == $past(wdata_i)));

  p_cmd_in_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ready_o);

  p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && wr_en_i && !addr_i && !wdata_i[B_INIT]) |=>
      (!cmd_valid_o && !ready_o && $stable(mask_o) && $stable(vec_base_o) && $stable(cascade_o)));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!cmd_valid_o && $stable(ready_o) && $stable(mask_o) &&
                  $stable(vec_base_o) && $stable(cascade_o) && $stable(single_o)));
endmodule

bind pic_init_seq pic_init_seq_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .ready_o, .word4_req_o, .single_o,
  .vec_base_o, .cascade_o, .special_nest_o, .is_master_o, .auto_eoi_o, .proc_mode_o,
  .mask_o, .cmd_valid_o, .cmd_data_o
);

// File: tb/sim_pic_init_seq.sv
`timescale 1ns/1ps
module sim_pic_init_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wd = '0;

  logic       ready, w4req, single, intv, level, sfn, ms, aeoi, pm, cv;
  logic [2:0] ahi;
  logic [7:0] vec, casc, mask, cd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pic_init_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr), .wdata_i(wd),
    .ready_o(ready), .word4_req_o(w4req), .single_o(single), .interval4_o(intv),
    .level_trig_o(level), .addr_hi_o(ahi), .vec_base_o(vec), .cascade_o(casc),
    .special_nest_o(sfn), .is_master_o(ms), .auto_eoi_o(aeoi), .proc_mode_o(pm),
    .mask_o(mask), .cmd_valid_o(cv), .cmd_data_o(cd)
  );

  // behavioural model: 0 idle, 2..4 waiting for that word, 9 running
  int         m_st;
  bit         m_need4, m_single, m_intv, m_level, m_sfn, m_ms, m_aeoi, m_pm, m_cv;
  bit [2:0]   m_ahi;
  bit [7:0]   m_vec, m_casc, m_mask, m_cd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; {m_need4, m_single, m_intv, m_level, m_sfn, m_ms, m_aeoi, m_pm, m_cv} = '0;
      m_ahi = 0; m_vec = 0; m_casc = 0; m_mask = 0; m_cd = 0;
    end else begin
      m_cv = 0;
      if (wr && !addr && wd[4]) begin
        m_need4 = wd[0]; m_single = wd[1]; m_intv = wd[2]; m_level = wd[3]; m_ahi = wd[7:5];
        m_vec = 0; m_casc = 0; m_mask = 0; {m_sfn, m_ms, m_aeoi, m_pm} = '0;
        m_st = 2;
      end else if (wr && addr) begin
        if (m_st == 2) begin
          m_vec = wd;
          m_st = !m_single ? 3 : (m_need4 ? 4 : 9);
        end else if (m_st == 3) begin
          m_casc = wd;
          m_st = m_need4 ? 4 : 9;
        end else if (m_st == 4) begin
          m_sfn = wd[4]; m_ms = wd[2]; m_aeoi = wd[1]; m_pm = wd[0];
          m_st = 9;
        end else if (m_st == 9) begin
          m_mask = wd;
        end
      end else if (wr && !addr && m_st == 9) begin
        m_cv = 1; m_cd = wd;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 ready", {7'd0, ready}, {7'd0, m_st == 9});
      chk("R2 opening fields", {w4req, single, intv, level, 1'b0, ahi},
          {m_need4, m_single, m_intv, m_level, 1'b0, m_ahi});
      chk("R3 vec_base", vec, m_vec);
      chk("R4 cascade", casc, m_casc);
      chk("R5 mode fields", {4'd0, sfn, ms, aeoi, pm}, {4'd0, m_sfn, m_ms, m_aeoi, m_pm});
      chk("R8 mask", mask, m_mask);
      chk("R9 cmd_valid", {7'd0, cv}, {7'd0, m_cv});
      if (m_cv) chk("R9 cmd_data", cd, m_cd);
    end
  end

  task automatic wr_byte(bit a, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wd = d;
    @(negedge clk);
    wr = 1'b0; addr = 1'b0; wd = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset ready", {7'd0, ready}, 8'd0);
    chk("R1 reset mask", mask, 8'd0);
    chk("R1 reset cfg", vec | casc | {w4req, single, intv, level, sfn, ms, aeoi, pm}, 8'd0);
    rst_n = 1'b1;
    idle(2);

    // R10: bit-4-clear writes before setup ignored
    wr_byte(0, 8'h20);
    chk("R10 no cmd before ready", {7'd0, cv}, 8'd0);

    // single, no mode word: 0xBA = addr bits 101, level, single
    wr_byte(0, 8'hBA);
    chk("R2 ready dropped", {7'd0, ready}, 8'd0);
    wr_byte(0, 8'h0B);  // R10: ignored mid-sequence
    chk("R10 ignored mid-seq", vec, 8'h00);
    wr_byte(1, 8'h40);
    chk("R7 ready after word2", {7'd0, ready}, 8'd1);
    chk("R6 cascade skipped", casc, 8'h00);
    chk("R6 mode skipped", {4'd0, sfn, ms, aeoi, pm}, 8'h00);
    wr_byte(1, 8'h5A);
    chk("R8 mask load", mask, 8'h5A);
    wr_byte(0, 8'h20);
    idle(1);
    chk("R11 idle cmd low", {7'd0, cv}, 8'd0);

    // cascade with mode word
    wr_byte(0, 8'h15);
    chk("R2 mask cleared", mask, 8'h00);
    wr_byte(1, 8'h20);
    chk("R4 waits map", {7'd0, ready}, 8'd0);
    wr_byte(1, 8'h84);
    chk("R5 waits mode", {7'd0, ready}, 8'd0);
    wr_byte(1, 8'hFF);
    chk("R5 mode bits", {4'd0, sfn, ms, aeoi, pm}, 8'h0F);
    chk("R4 cascade map", casc, 8'h84);
    wr_byte(0, 8'h0A);
    wr_byte(0, 8'h60);
    idle(3);

    // single with mode word
    wr_byte(0, 8'h13);
    wr_byte(1, 8'h08);
    chk("R4 no map in single", {7'd0, ready}, 8'd0);
    wr_byte(1, 8'h05);
    chk("R5 ready after mode", {7'd0, ready}, 8'd1);

    // cascade without mode word, restart mid-sequence
    wr_byte(0, 8'h14);
    wr_byte(1, 8'h77);
    wr_byte(0, 8'hF4);  // R2: restart during map wait
    chk("R2 restart clears vec", vec, 8'h00);
    wr_byte(1, 8'h90);
    wr_byte(1, 8'h03);
    chk("R4 slave id", casc, 8'h03);
    chk("R7 ready no mode", {7'd0, ready}, 8'd1);
    // back-to-back run-time writes
    wr_byte(1, 8'hC3);
    wr_byte(0, 8'h0E);
    wr_byte(0, 8'h27);
    idle(4);
    chk("R11 mask held", mask, 8'hC3);

    summary();
  end
endmodule